// File: doc/BRIEF.md
# Shared Bus Default-Driver Control

Several lookup devices in a cascaded bank share two groups of three-state lines. One group carries the external SRAM address, chip-enable and write-enable. The other carries the search status flag and valid. This block sits in each device and produces two registered output enables, one per group. Across the whole bank, exactly one device drives each group in every cycle, so the board needs no pull resistors on these lines.

Each device has two static configuration bits. The first names it the fallback owner of the SRAM group. The second names it the fallback owner of the status group. On a search that hits, the winning device takes both groups. On idle cycles, on other accesses and on searches that miss everywhere, ownership falls back to the configured defaults.

A learn stores a comparand at the next free entry of the one learning device. The SRAM write follows a fixed number of cycles later. For that write the default owner releases the SRAM group for two cycles, and the learning device drives the group in the second of them. The first of the two cycles is a turnaround gap.

Top module: `shared_bus_owner_ctrl`

## Requirements
- R1: A synchronous reset clears both enables in the cycle after it is sampled and cancels any learn still in flight.
- R2: Command codes are 0 idle, 1 search, 2 learn and 3 other access. Enables are registered and reflect the command of the previous cycle. For codes 0, 2 and 3, outside the learn release window, `oe_sram` equals `cfg_sram_dflt`.
- R3: For a search with `hit_win` high and `global_miss` low, both `oe_sram` and `oe_stat` are high.
- R4: For a search with `global_miss` low and `hit_win` low, both enables are low.
- R5: For a search with `global_miss` high, `oe_sram` equals `cfg_sram_dflt` and `oe_stat` equals `cfg_stat_dflt`.
- R6: For any command other than search, `oe_stat` equals `cfg_stat_dflt`. Learns do not change this.
- R7: For a learn issued in cycle t, `oe_sram` is low in cycle t+LEARN_LAT on every device. This is the gap cycle before the SRAM write.
- R8: In cycle t+LEARN_LAT+1, the write cycle, `oe_sram` equals the `learn_sel` captured with that learn. The write cycle takes priority over a gap cycle of a later learn.
- R9: In a bank with one default bit of each kind set, at most one device enables each group in every cycle. Exactly one does, except in a gap cycle of the SRAM group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sram_dflt | input | 1 | This device is fallback owner of the SRAM group |
| cfg_stat_dflt | input | 1 | This device is fallback owner of the status group |
| cmd_op | input | 2 | Command code of the current cycle |
| hit_win | input | 1 | This device wins the current search |
| global_miss | input | 1 | No device in the bank hit the current search |
| learn_sel | input | 1 | This device is the one that learns on the current learn |
| oe_sram | output | 1 | Drive enable for SRAM address, chip-enable and write-enable |
| oe_stat | output | 1 | Drive enable for search status flag and valid |

## Verification
A wrong fallback or hit decision shows up on the enables one cycle after the command. In the modelled bank it appears either as two drivers on one group or as a floating group. A fault in the learn delay line stays hidden until LEARN_LAT or LEARN_LAT+1 cycles after the learn. It then shows as a missing gap, a misplaced write owner, or a release that persists after reset. The bench drives four instances together and compares every enable with a model on every cycle. It covers back-to-back learns and reset in the middle of a learn.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_SEARCH = 2'd1,
    OP_LEARN  = 2'd2,
    OP_ACCESS = 2'd3
  } bdc_op_e;

  typedef struct packed {
    logic vld;
    logic mine;
  } bdc_stage_t;
endpackage

// File: rtl/bdc_owner_decode.sv
module bdc_owner_decode
  import bdc_pkg::*;
(
  input  logic [1:0] op,
  input  logic       hit_win,
  input  logic       global_miss,
  input  logic       sram_dflt,
  input  logic       stat_dflt,
  output logic       base_sram,
  output logic       base_stat
);
  bdc_op_e op_e;
  assign op_e = bdc_op_e'(op);

  always_comb begin
    base_sram = sram_dflt;
    base_stat = stat_dflt;
    if (op_e == OP_SEARCH) begin
      if (global_miss) begin
        base_sram = sram_dflt;
        base_stat = stat_dflt;
      end else begin
        base_sram = hit_win;
        base_stat = hit_win;
      end
    end
  end
endmodule

// File: rtl/bdc_learn_window.sv
module bdc_learn_window
  import bdc_pkg::*;
#(
  parameter int LEARN_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic learn_now,
  input  logic learn_mine,
  output logic gap,
  output logic wr,
  output logic wr_mine
);
  bdc_stage_t st [LEARN_LAT];

  for (genvar g = 0; g < LEARN_LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= '{vld: learn_now, mine: learn_now & learn_mine};
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= st[g-1];
      end
    end
  end

  if (LEARN_LAT == 1) begin : g_gap_now
    assign gap = learn_now;
  end else begin : g_gap_pipe
    assign gap = st[LEARN_LAT-2].vld;
  end

  assign wr      = st[LEARN_LAT-1].vld;
  assign wr_mine = st[LEARN_LAT-1].mine;
endmodule

// File: rtl/shared_bus_owner_ctrl.sv
module shared_bus_owner_ctrl
  import bdc_pkg::*;
#(
  parameter int LEARN_LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sram_dflt,
  input  logic       cfg_stat_dflt,
  input  logic [1:0] cmd_op,
  input  logic       hit_win,
  input  logic       global_miss,
  input  logic       learn_sel,
  output logic       oe_sram,
  output logic       oe_stat
);
  logic base_sram, base_stat;
  logic win_gap, win_wr, win_wr_mine;
  logic is_learn;

  assign is_learn = (bdc_op_e'(cmd_op) == OP_LEARN);

  bdc_owner_decode u_dec (
    .op          (cmd_op),
    .hit_win     (hit_win),
    .global_miss (global_miss),
    .sram_dflt   (cfg_sram_dflt),
    .stat_dflt   (cfg_stat_dflt),
    .base_sram   (base_sram),
    .base_stat   (base_stat)
  );

  bdc_learn_window #(.LEARN_LAT(LEARN_LAT)) u_win (
    .clk        (clk),
    .rst        (rst),
    .learn_now  (is_learn),
    .learn_mine (learn_sel),
    .gap        (win_gap),
    .wr         (win_wr),
    .wr_mine    (win_wr_mine)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_sram <= 1'b0;
      oe_stat <= 1'b0;
    end else begin
      oe_stat <= base_stat;
      if (win_wr)       oe_sram <= win_wr_mine;
      else if (win_gap) oe_sram <= 1'b0;
      else              oe_sram <= base_sram;
    end
  end
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
  parameter int LEARN_LAT = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_sram_dflt,
  input logic       cfg_stat_dflt,
  input logic [1:0] cmd_op,
  input logic       hit_win,
  input logic       global_miss,
  input logic       learn_sel,
  input logic       oe_sram,
  input logic       oe_stat
);
  localparam int CW   = $clog2(LEARN_LAT + 2) + 1;
  localparam int CMAX = LEARN_LAT + 1;

  logic [CW-1:0] since;
  logic          lrn_who;

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= CW'(CMAX);
      lrn_who <= 1'b0;
    end else if (cmd_op == 2'd2) begin
      since   <= '0;
      lrn_who <= learn_sel;
    end else if (since < CW'(CMAX)) begin
      since <= since + 1'b1;
    end
  end

  logic quiet;
  assign quiet = (since > CW'(LEARN_LAT));

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!oe_sram && !oe_stat));

  a_r2_fallback_sram: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_op) != 2'd1 && !$past(rst) && quiet) |-> (oe_sram == $past(cfg_sram_dflt)));

  a_r3_winner_drives: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_op) == 2'd1 && $past(hit_win) && !$past(global_miss) && !$past(rst) && quiet)
      |-> (oe_sram && oe_stat));

  a_r4_loser_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_op) == 2'd1 && !$past(hit_win) && !$past(global_miss) && !$past(rst) && quiet)
      |-> (!oe_sram && !oe_stat));

  a_r5_miss_fallback: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_op) == 2'd1 && $past(global_miss) && !$past(rst) && quiet)
      |-> (oe_sram == $past(cfg_sram_dflt) && oe_stat == $past(cfg_stat_dflt)));

  a_r6_status_fallback: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_op) != 2'd1 && !$past(rst)) |-> (oe_stat == $past(cfg_stat_dflt)));

  a_r8_write_owner: assert property (@(posedge clk) disable iff (rst)
    (since == CW'(LEARN_LAT)) |-> (oe_sram == lrn_who));
endmodule

bind shared_bus_owner_ctrl bdc_checker #(.LEARN_LAT(LEARN_LAT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_sram_dflt (cfg_sram_dflt),
  .cfg_stat_dflt (cfg_stat_dflt),
  .cmd_op        (cmd_op),
  .hit_win       (hit_win),
  .global_miss   (global_miss),
  .learn_sel     (learn_sel),
  .oe_sram       (oe_sram),
  .oe_stat       (oe_stat)
);

// File: tb/tb_shared_bus_owner_ctrl.sv
`timescale 1ns/100ps
module tb_shared_bus_owner_ctrl;
  localparam int N   = 4;
  localparam int LAT = 2;
  localparam int HD  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic gmiss = 1'b0;
  logic [N-1:0] win = '0, lsel = '0, dsram = '0, dstat = '0;
  logic [N-1:0] oe_sram, oe_stat;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dev
    shared_bus_owner_ctrl #(.LEARN_LAT(LAT)) dut (
      .clk           (clk),
      .rst           (rst),
      .cfg_sram_dflt (dsram[g]),
      .cfg_stat_dflt (dstat[g]),
      .cmd_op        (cmd),
      .hit_win       (win[g]),
      .global_miss   (gmiss),
      .learn_sel     (lsel[g]),
      .oe_sram       (oe_sram[g]),
      .oe_stat       (oe_stat[g])
    );
  end

  int n_chk = 0, n_bad = 0, cyc = HD;
  bit done = 0;
  int h_cmd [HD];
  int h_who [HD];
  bit h_miss[HD];
  int d_sram = 0, d_stat = 0;

  function automatic bit exp_sram(int d, int c);
    int cw = h_cmd[(c - LAT) % HD];
    int cg = h_cmd[(c - LAT + 1) % HD];
    int cc = h_cmd[c % HD];
    if (cw == 2) return (h_who[(c - LAT) % HD] == d);
    if (cg == 2) return 1'b0;
    if (cc == 1 && !h_miss[c % HD]) return (h_who[c % HD] == d);
    return (d == d_sram);
  endfunction

  function automatic bit exp_stat(int d, int c);
    if (h_cmd[c % HD] == 1 && !h_miss[c % HD]) return (h_who[c % HD] == d);
    return (d == d_stat);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(int op, bit miss, int who);
    cmd   = 2'(op);
    gmiss = miss;
    win   = '0;
    lsel  = '0;
    if (op == 1 && !miss) win[who] = 1'b1;
    if (op == 2) lsel[who] = 1'b1;
    h_cmd[cyc % HD]  = op;
    h_miss[cyc % HD] = miss;
    h_who[cyc % HD]  = who;
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < N; d++) begin
      string rs = (h_cmd[(cyc - LAT) % HD] == 2) ? "R8" :
                  (h_cmd[(cyc - LAT + 1) % HD] == 2) ? "R7" :
                  (op == 1) ? (miss ? "R5" : (d == who ? "R3" : "R4")) : "R2";
      string rt = (op == 1) ? (miss ? "R5" : (d == who ? "R3" : "R4")) : "R6";
      chk(rs, int'(oe_sram[d]), int'(exp_sram(d, cyc)));
      chk(rt, int'(oe_stat[d]), int'(exp_stat(d, cyc)));
    end
    begin
      bit gapc = (h_cmd[(cyc - LAT) % HD] != 2) && (h_cmd[(cyc - LAT + 1) % HD] == 2);
      chk("R9 sram drivers", $countones(oe_sram), gapc ? 0 : 1);
      chk("R9 stat drivers", $countones(oe_stat), 1);
    end
    cyc++;
  endtask

  task automatic do_reset(int ds, int dt);
    d_sram = ds;
    d_stat = dt;
    dsram = '0; dsram[ds] = 1'b1;
    dstat = '0; dstat[dt] = 1'b1;
    cmd = 2'd0; win = '0; lsel = '0; gmiss = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 oe_sram reset", int'(oe_sram), 0);
    chk("R1 oe_stat reset", int'(oe_stat), 0);
    rst = 1'b0;
    for (int i = 0; i < HD; i++) begin
      h_cmd[i] = 0; h_who[i] = 0; h_miss[i] = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(0, 2);
    // R2, R6: idle and other access fall back to defaults
    step(0, 0, 0); step(3, 0, 0);
    // R3, R4: search hit, device 3 wins
    step(1, 0, 3);
    // R5: global miss
    step(1, 1, 0);
    // R7, R8: learn by a non-default device, then quiet
    step(2, 0, 1); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    // R8: back-to-back learns, second by the default device
    step(2, 0, 2); step(2, 0, 0); step(3, 0, 0); step(0, 0, 0); step(0, 0, 0);
    // R1: reset while a learn is in flight cancels its release window
    step(2, 0, 3);
    do_reset(1, 1);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int seg = 0; seg < 6; seg++) begin
      do_reset(int'($urandom_range(N - 1)), int'($urandom_range(N - 1)));
      for (int i = 0; i < 400; i++) begin
        int  op  = int'($urandom_range(3));
        bit  ms  = ($urandom_range(3) == 0);
        int  who = int'($urandom_range(N - 1));
        step(op, ms, who);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule